// File: doc/BRIEF.md
# Character Raster Generator

This block generates the raster timing and display-memory addressing for a monochrome text screen of 32 rows by 64 characters. It runs from a dot clock of 8 MHz. Each scan line is 512 dots long (64 us): 384 dots of picture and 128 blanked dots, with a 32-dot line sync pulse in the blanked part. Each frame is 313 lines. The first 256 lines carry picture. The vertical sync pulse lasts 4 lines and is placed 13 lines after the picture ends. It is followed by 40 more blank lines before the picture starts again.

Every character cell is 6 dots wide and 8 lines tall. Each cell period is split into two parts. In the first four dots the block drives the display-RAM address of the character. In the last two dots (250 ns) a processor can read or write the same RAM. The character byte is decoded in one of two ways. With bit 7 clear it is a text glyph drawn at full intensity from a small computed glyph table. With bit 7 set it is a 2x2 block-graphics cell whose lit quadrants take a 3-bit gray shade. The resulting pixels go through a shift register, so the video trails the counters by exactly six dots. The output is a 3-bit level for an external resistor ladder, together with blanking and composite sync.

Top module: `char_raster_gen`

## Requirements
- R1: After reset the dot and line positions start at zero and advance by one dot per clock. A line is 512 dots and a frame is 313 lines, after which the next frame begins at line 0, dot 0.
- R2: `hsync_n` is low for dots 410 to 441 of every line (32 dots) and high on all other dots.
- R3: `vsync_n` is low for the whole of lines 269 to 272 and high on all other lines. `csync_n` is low exactly when one, and only one, of the line sync and the frame sync is active.
- R4: During dots 0 to 3 of cell k (dots 6k to 6k+3) on line L, `ram_addr` equals (L[7:3] mod 32) * 64 + (k mod 64).
- R5: During dots 4 and 5 of each cell, `ram_addr` equals `cpu_addr`. A request held at dot 4 produces exactly one one-clock `ram_we` at dot 4 if it is a write. It also produces a one-clock `cpu_ack` in the clock after dot 5, with `cpu_rdata` then holding the byte stored at `cpu_addr` if it is a read. Without a request, `ram_we` stays low.
- R6: Pixel j (0 to 5) of cell k on line L is output at dot 6k+6+j. `blank_n` is high for these pixels exactly when k < 64 and L < 256. `video` is 0 whenever `blank_n` is low.
- R7: For a code c with bit 7 = 0 on cell line r = L mod 8, pixel column 0 and cell line 0 are dark. Column j (1 to 5) is lit at level 7 when bit (5-j) of c[4:0] XOR {r[2:0], c[6:5]} is 1, and is 0 otherwise.
- R8: For a code c with bit 7 = 1, the pixel in column j on cell line r reads bit q of c[3:0], where q = 2*(r >= 4) + (j >= 3). When that bit is 1 the pixel level is c[6:4]; when it is 0 the level is 0.
- R9: `glyph_row` equals the current line number mod 8.
- R10: While reset is held, `hsync_n`, `vsync_n` and `csync_n` are high, `blank_n`, `video`, `glyph_row`, `ram_we` and `cpu_ack` are 0, and `ram_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor requests a display-RAM access |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | 11 | Processor offset into display RAM |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_ack | output | 1 | One-clock pulse when the access slot has served the request |
| cpu_rdata | output | 8 | Byte read in the last served read |
| ram_addr | output | 11 | Display-RAM address |
| ram_we | output | 1 | Display-RAM write strobe |
| ram_wdata | output | 8 | Display-RAM write byte |
| ram_rdata | input | 8 | Display-RAM read byte, one clock after the address |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| blank_n | output | 1 | High while the output pixel lies in the picture |
| glyph_row | output | 3 | Line within the character cell |
| video | output | 3 | Gray level of the current pixel |

## Verification
Some rules hold on every cycle, and the assertions check these. The dot position wraps at 512 and the line position wraps at 313. The line sync pulse is exactly 32 dots wide. The frame sync only starts on the first dot of a line. Blanked dots are always dark. A RAM write always goes to the processor's address, and each acknowledge lasts one clock. The bench scenarios show what only specific RAM contents and chosen times can reveal: the six-dot delay of the pixels, the text and quadrant decoding with its shades, the row field of the address wrapping, and a processor write that appears on screen in the following frame.

// File: rtl/char_raster_pkg.sv
// Shared types and the computed glyph table of the character raster generator.
// Assumes a 3-bit gray level and a 5-dot glyph body inside a 6-dot cell.
package char_raster_pkg;

    localparam int LEVEL_W = 3;
    localparam int GLYPH_W = 5;

    typedef logic [LEVEL_W-1:0] level_t;

    // Raster decode flags for one dot position.
    typedef struct packed {
        logic disp;   // dot lies inside the picture window
        logic hs;     // line sync active
        logic vs;     // frame sync active
    } raster_flags_t;

    // Placeholder glyph table: body bits of a text code on one cell line.
    function automatic logic [GLYPH_W-1:0] glyph_bits(input logic [6:0] code,
                                                       input logic [2:0] row);
        return code[4:0] ^ {row, code[6:5]};
    endfunction

endpackage

// File: rtl/raster_counters.sv
// Dot, line, cell-phase and cell-column counters.
// Assumes a synchronous active-low reset; all counters restart at zero on a line wrap.
module raster_counters #(
    parameter int H_TOTAL = 512,
    parameter int V_TOTAL = 313,
    parameter int CELL_W  = 6,
    localparam int HW     = $clog2(H_TOTAL),
    localparam int VW     = $clog2(V_TOTAL),
    localparam int PH_W   = $clog2(CELL_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [HW-1:0]   hcnt,
    output logic [VW-1:0]   vcnt,
    output logic [PH_W-1:0] phase,
    output logic [HW-1:0]   col
);

    logic line_end;
    assign line_end = (hcnt == HW'(H_TOTAL - 1));

    // Advance the dot position and wrap into the next line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Advance the line position at the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcnt <= '0;
        end else if (line_end) begin
            vcnt <= (vcnt == VW'(V_TOTAL - 1)) ? '0 : vcnt + 1'b1;
        end
    end

    // Step the dot within the cell and the cell column.
    always_ff @(posedge clk) begin
        if (!rst_n || line_end) begin
            phase <= '0;
            col   <= '0;
        end else if (phase == PH_W'(CELL_W - 1)) begin
            phase <= '0;
            col   <= col + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/sync_decode.sv
// Decodes picture window, line sync and frame sync from the raster counters.
// Assumes the picture begins at dot 0 of line 0; purely combinational.
module sync_decode
    import char_raster_pkg::*;
#(
    parameter int H_ACTIVE = 384,
    parameter int H_FRONT  = 26,
    parameter int H_SYNC   = 32,
    parameter int V_ACTIVE = 256,
    parameter int V_FRONT  = 13,
    parameter int V_SYNC   = 4,
    parameter int HW       = 9,
    parameter int VW       = 9,
    localparam int HS_BEG  = H_ACTIVE + H_FRONT,
    localparam int HS_END  = HS_BEG + H_SYNC,
    localparam int VS_BEG  = V_ACTIVE + V_FRONT,
    localparam int VS_END  = VS_BEG + V_SYNC
) (
    input  logic [HW-1:0]  hcnt,
    input  logic [VW-1:0]  vcnt,
    output raster_flags_t  flags
);

    // Window comparisons for the current dot.
    always_comb begin
        flags.disp = (hcnt < HW'(H_ACTIVE)) && (vcnt < VW'(V_ACTIVE));
        flags.hs   = (hcnt >= HW'(HS_BEG)) && (hcnt < HW'(HS_END));
        flags.vs   = (vcnt >= VW'(VS_BEG)) && (vcnt < VW'(VS_END));
    end

endmodule

// File: rtl/fetch_arbiter.sv
// Shares the display RAM between character fetches and a processor slot.
// Assumes a RAM with one clock of read latency; dots below SLOT_START fetch
// characters and the remaining dots of each cell belong to the processor.
module fetch_arbiter #(
    parameter int CELL_W      = 6,
    parameter int SLOT_PHASES = 2,
    parameter int COL_W       = 6,
    parameter int ROW_W       = 5,
    parameter int RW          = 3,
    parameter int HW          = 9,
    parameter int VW          = 9,
    localparam int ADDR_W     = COL_W + ROW_W,
    localparam int PH_W       = $clog2(CELL_W),
    localparam int SLOT_START = CELL_W - SLOT_PHASES,
    localparam int FETCH_LAST = SLOT_START - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase,
    input  logic [HW-1:0]     col,
    input  logic [VW-1:0]     vcnt,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              cpu_ack,
    output logic [7:0]        cpu_rdata,
    output logic [7:0]        char_q
);

    logic              in_slot;
    logic              slot_first;
    logic [ADDR_W-1:0] vid_addr;
    logic              taken;
    logic              taken_rd;

    // Address of the character under the counters: cell row, then column.
    assign vid_addr   = {vcnt[RW +: ROW_W], col[COL_W-1:0]};
    assign in_slot    = (phase >= PH_W'(SLOT_START));
    assign slot_first = (phase == PH_W'(SLOT_START));

    // Select the RAM master and strobe a write once per slot.
    always_comb begin
        ram_addr = in_slot ? cpu_addr : vid_addr;
        ram_we   = slot_first && cpu_req && cpu_we;
    end

    // Latch the fetched character before the slot begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q <= '0;
        end else if (phase == PH_W'(FETCH_LAST)) begin
            char_q <= ram_rdata;
        end
    end

    // Take a request at the slot start and close it at the cell end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken     <= 1'b0;
            taken_rd  <= 1'b0;
            cpu_ack   <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            cpu_ack <= 1'b0;
            if (slot_first) begin
                taken    <= cpu_req;
                taken_rd <= cpu_req && !cpu_we;
            end
            if (phase == PH_W'(CELL_W - 1)) begin
                cpu_ack  <= taken;
                taken    <= 1'b0;
                taken_rd <= 1'b0;
                if (taken_rd) begin
                    cpu_rdata <= ram_rdata;
                end
            end
        end
    end

endmodule

// File: rtl/pixel_path.sv
// Decodes a character byte into one cell line of gray levels and shifts them out.
// Assumes a 6x8 cell with a 5-dot glyph body; load arrives on the last dot of a cell.
module pixel_path
    import char_raster_pkg::*;
#(
    parameter int CELL_W = 6,
    parameter int CELL_H = 8,
    localparam int RW    = $clog2(CELL_H),
    localparam int SR_W  = CELL_W * LEVEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          disp,
    input  logic [RW-1:0] row,
    input  logic [7:0]    char_q,
    output level_t        video,
    output logic          blank_n
);

    logic [GLYPH_W-1:0] glyph;
    logic [SR_W-1:0]    pix;
    logic [SR_W-1:0]    sr;
    logic               valid_q;
    logic               lower_half;

    assign glyph      = glyph_bits(char_q[6:0], row);
    assign lower_half = (row >= RW'(CELL_H / 2));

    // One decoder per pixel column of the cell.
    for (genvar j = 0; j < CELL_W; j++) begin : g_pix
        localparam logic RIGHT_HALF = (j >= CELL_W / 2);
        logic [1:0] quad;
        logic       gfx_on;
        logic       txt_on;
        assign quad   = {lower_half, RIGHT_HALF};
        assign gfx_on = char_q[quad];
        if (j == 0) begin : g_gap
            assign txt_on = 1'b0;
        end else begin : g_body
            assign txt_on = (row != '0) && glyph[CELL_W - 1 - j];
        end
        assign pix[j*LEVEL_W +: LEVEL_W] =
            char_q[7] ? (gfx_on ? char_q[6:4] : '0) : (txt_on ? '1 : '0);
    end

    // Load a cell line, otherwise shift toward the output slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr      <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            sr      <= pix;
            valid_q <= disp;
        end else begin
            sr <= {LEVEL_W'(0), sr[SR_W-1:LEVEL_W]};
        end
    end

    assign video   = valid_q ? sr[LEVEL_W-1:0] : '0;
    assign blank_n = valid_q;

endmodule

// File: rtl/char_raster_gen.sv
// Character raster generator: counters, sync decode, shared RAM fetch and pixel path.
// Assumes an 8 MHz dot clock, a display RAM with one clock of read latency, and
// synchronous active-low reset.
module char_raster_gen
    import char_raster_pkg::*;
#(
    parameter int CELL_W      = 6,
    parameter int CELL_H      = 8,
    parameter int COLS        = 64,
    parameter int ROWS        = 32,
    parameter int H_TOTAL     = 512,
    parameter int H_FRONT     = 26,
    parameter int H_SYNC      = 32,
    parameter int V_TOTAL     = 313,
    parameter int V_FRONT     = 13,
    parameter int V_SYNC      = 4,
    parameter int SLOT_PHASES = 2,
    localparam int H_ACTIVE   = COLS * CELL_W,
    localparam int V_ACTIVE   = ROWS * CELL_H,
    localparam int HW         = $clog2(H_TOTAL),
    localparam int VW         = $clog2(V_TOTAL),
    localparam int COL_W      = $clog2(COLS),
    localparam int ROW_W      = $clog2(ROWS),
    localparam int RW         = $clog2(CELL_H),
    localparam int PH_W       = $clog2(CELL_W),
    localparam int ADDR_W     = COL_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic              cpu_ack,
    output logic [7:0]        cpu_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              csync_n,
    output logic              blank_n,
    output logic [RW-1:0]     glyph_row,
    output logic [LEVEL_W-1:0] video
);

    logic [HW-1:0]   hcnt;
    logic [VW-1:0]   vcnt;
    logic [PH_W-1:0] phase;
    logic [HW-1:0]   col;
    logic [7:0]      char_q;
    logic            load;
    raster_flags_t   flags;

    raster_counters #(
        .H_TOTAL (H_TOTAL),
        .V_TOTAL (V_TOTAL),
        .CELL_W  (CELL_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .hcnt  (hcnt),
        .vcnt  (vcnt),
        .phase (phase),
        .col   (col)
    );

    sync_decode #(
        .H_ACTIVE (H_ACTIVE),
        .H_FRONT  (H_FRONT),
        .H_SYNC   (H_SYNC),
        .V_ACTIVE (V_ACTIVE),
        .V_FRONT  (V_FRONT),
        .V_SYNC   (V_SYNC),
        .HW       (HW),
        .VW       (VW)
    ) u_sync (
        .hcnt  (hcnt),
        .vcnt  (vcnt),
        .flags (flags)
    );

    fetch_arbiter #(
        .CELL_W      (CELL_W),
        .SLOT_PHASES (SLOT_PHASES),
        .COL_W       (COL_W),
        .ROW_W       (ROW_W),
        .RW          (RW),
        .HW          (HW),
        .VW          (VW)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .col       (col),
        .vcnt      (vcnt),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .ram_rdata (ram_rdata),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .cpu_ack   (cpu_ack),
        .cpu_rdata (cpu_rdata),
        .char_q    (char_q)
    );

    // The cell's pixels are loaded on its last dot, six dots behind the counters.
    assign load = (phase == PH_W'(CELL_W - 1));

    pixel_path #(
        .CELL_W (CELL_W),
        .CELL_H (CELL_H)
    ) u_pix (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .disp    (flags.disp),
        .row     (vcnt[RW-1:0]),
        .char_q  (char_q),
        .video   (video),
        .blank_n (blank_n)
    );

    // Sync outputs; composite sync inverts the line pulse during frame sync.
    assign hsync_n   = ~flags.hs;
    assign vsync_n   = ~flags.vs;
    assign csync_n   = ~(flags.hs ^ flags.vs);
    assign glyph_row = vcnt[RW-1:0];
    assign ram_wdata = cpu_wdata;

endmodule

// File: rtl/char_raster_chk.sv
// Cycle-level checks of the character raster generator, bound to its top module.
// Assumes synchronous active-low reset; all properties are disabled during reset.
module char_raster_chk #(
    parameter int H_TOTAL = 512,
    parameter int V_TOTAL = 313,
    parameter int H_SYNC  = 32,
    parameter int HW      = 9,
    parameter int VW      = 9,
    parameter int ADDR_W  = 11,
    parameter int LEVEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HW-1:0]     hcnt,
    input logic [VW-1:0]     vcnt,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              blank_n,
    input logic [LEVEL_W-1:0] video,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ack
);

    logic [HW-1:0] hs_len;

    // Count the dots of the current line sync pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_len <= '0;
        end else if (!hsync_n) begin
            hs_len <= hs_len + 1'b1;
        end else begin
            hs_len <= '0;
        end
    end

    AST_HCNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == HW'(H_TOTAL - 1)) |=> (hcnt == '0)); // R1
    AST_VCNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == HW'(H_TOTAL - 1) && vcnt == VW'(V_TOTAL - 1)) |=> (vcnt == '0)); // R1
    AST_HSYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (hs_len == HW'(H_SYNC))); // R2
    AST_VSYNC_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> (hcnt == '0)); // R3
    AST_WE_CPU_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr == cpu_addr)); // R5
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack); // R5
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> (video == '0)); // R6

endmodule

bind char_raster_gen char_raster_chk #(
    .H_TOTAL (H_TOTAL),
    .V_TOTAL (V_TOTAL),
    .H_SYNC  (H_SYNC),
    .HW      (HW),
    .VW      (VW),
    .ADDR_W  (ADDR_W),
    .LEVEL_W (char_raster_pkg::LEVEL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hcnt     (hcnt),
    .vcnt     (vcnt),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .blank_n  (blank_n),
    .video    (video),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .cpu_addr (cpu_addr),
    .cpu_ack  (cpu_ack)
);

// File: tb/char_raster_gen_bench.sv
// Self-checking bench: a pixel vector table walked in one frame, then directed
// checks of reset, sync, addressing, the processor slot and the frame wrap.
module char_raster_gen_bench;

    localparam int LINE = 512;

    typedef struct packed {
        logic [8:0]  line;
        logic [5:0]  col;
        logic [7:0]  code;
        logic [17:0] exp;   // pixel 0 in the top octal digit
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [0:NV-1] = '{
        '{9'd0,   6'd5,  8'h1F, 18'o000000},  // text, cell line 0 dark
        '{9'd1,   6'd0,  8'h00, 18'o000700},  // text, column 0 of the line
        '{9'd10,  6'd63, 8'h55, 18'o077777},  // text, last column
        '{9'd19,  6'd11, 8'hFA, 18'o000777},  // graphics, upper half, shade 7
        '{9'd20,  6'd10, 8'hA5, 18'o222000},  // graphics, lower half, shade 2
        '{9'd31,  6'd32, 8'hCF, 18'o444444},  // graphics, all quadrants lit
        '{9'd100, 6'd40, 8'h41, 18'o070077},  // text, mixed pattern
        '{9'd255, 6'd1,  8'h60, 18'o077777},  // last picture line
        '{9'd256, 6'd1,  8'hFF, 18'o000000}   // first blank line
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [10:0] cpu_addr = 11'h123;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_ack;
    logic [7:0]  cpu_rdata;
    logic [10:0] ram_addr;
    logic        ram_we;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = 8'h00;
    logic        hsync_n, vsync_n, csync_n, blank_n;
    logic [2:0]  glyph_row;
    logic [2:0]  video;

    logic [7:0]  mem [0:2047];
    int unsigned n_cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    char_raster_gen u_char_raster_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ack   (cpu_ack),
        .cpu_rdata (cpu_rdata),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .hsync_n   (hsync_n),
        .vsync_n   (vsync_n),
        .csync_n   (csync_n),
        .blank_n   (blank_n),
        .glyph_row (glyph_row),
        .video     (video)
    );

    // Display RAM model with one clock of read latency.
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        ram_rdata <= mem[ram_addr];
    end

    // Clocks since reset release; equals the dot index of the whole frame.
    always @(posedge clk) begin
        if (!rst_n) n_cyc <= 0;
        else        n_cyc <= n_cyc + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_to(input int unsigned n);
        while (n_cyc != n) @(negedge clk);
    endtask

    task automatic cpu_access(input logic we, input logic [10:0] a, input logic [7:0] d,
                              output logic [7:0] rd, output bit ok);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; ok = 1'b0;
        for (int i = 0; i < 14 && !ok; i++) begin
            @(negedge clk);
            if (cpu_ack) ok = 1'b1;
        end
        rd = cpu_rdata;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = 11'h123;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit ok;
        for (int a = 0; a < 2048; a++) mem[a] = 8'h80;
        for (int v = 0; v < NV; v++)
            mem[{VECS[v].line[7:3], VECS[v].col}] = VECS[v].code;

        // R10 reset state
        repeat (4) @(negedge clk);
        chk("R10 hsync_n", hsync_n, 1);
        chk("R10 vsync_n", vsync_n, 1);
        chk("R10 csync_n", csync_n, 1);
        chk("R10 blank_n", blank_n, 0);
        chk("R10 video", video, 0);
        chk("R10 glyph_row", glyph_row, 0);
        chk("R10 ram_we", ram_we, 0);
        chk("R10 cpu_ack", cpu_ack, 0);
        chk("R10 ram_addr", ram_addr, 0);
        rst_n = 1'b1;

        // R6 R7 R8 pixel vectors, six dots behind the cell timing
        for (int v = 0; v < NV; v++) begin
            for (int j = 0; j < 6; j++) begin
                wait_to(VECS[v].line * LINE + 6 * VECS[v].col + 6 + j);
                chk("R6 R7 R8 pixel", video, VECS[v].exp[(5 - j) * 3 +: 3]);
                chk("R6 blank_n", blank_n, (VECS[v].line < 256) ? 1 : 0);
            end
        end

        // R2 line sync edges, R3 composite equals line sync outside frame sync
        wait_to(258 * LINE + 409); chk("R2 hsync before", hsync_n, 1);
        wait_to(258 * LINE + 410); chk("R2 hsync first", hsync_n, 0);
        chk("R3 csync follows hsync", csync_n, 0);
        wait_to(258 * LINE + 441); chk("R2 hsync last", hsync_n, 0);
        wait_to(258 * LINE + 442); chk("R2 hsync after", hsync_n, 1);

        // R9 cell line index
        wait_to(261 * LINE + 100); chk("R9 glyph_row", glyph_row, 5);

        // R5 processor write then read through the slot
        wait_to(263 * LINE);
        cpu_access(1'b1, 11'd2, 8'h00, rd, ok);
        chk("R5 write ack", ok, 1);
        cpu_access(1'b0, 11'd1985, 8'h00, rd, ok);
        chk("R5 read ack", ok, 1);
        chk("R5 read data", rd, 8'h60);
        @(negedge clk);
        chk("R5 ack single pulse", cpu_ack, 0);

        // R3 frame sync lines and composite serration
        wait_to(268 * LINE + 5);   chk("R3 vsync before", vsync_n, 1);
        wait_to(269 * LINE);       chk("R3 vsync first", vsync_n, 0);
        wait_to(270 * LINE + 100); chk("R3 csync in frame sync", csync_n, 0);
        wait_to(270 * LINE + 420); chk("R3 csync serration", csync_n, 1);
        wait_to(272 * LINE + 511); chk("R3 vsync last", vsync_n, 0);
        wait_to(273 * LINE);       chk("R3 vsync after", vsync_n, 1);

        // R4 fetch address with the row field wrapped, R5 slot address
        wait_to(300 * LINE + 54); chk("R4 fetch addr", ram_addr, 329);
        wait_to(300 * LINE + 57); chk("R4 fetch addr dot 3", ram_addr, 329);
        wait_to(300 * LINE + 58); chk("R5 slot addr", ram_addr, 11'h123);
        chk("R5 no request no write", ram_we, 0);

        // R1 frame wrap; the written cell shows on line 1 of the next frame
        for (int j = 0; j < 6; j++) begin
            wait_to(313 * LINE + LINE + 18 + j);
            chk("R1 R5 next frame pixel", video, (j == 3) ? 7 : 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule